// File: doc/BRIEF.md
# Protection Input Qualifier

This block sits between the raw fault comparators of a switching regulator and the logic that decides how to recover from a fault. It turns noisy, edge-sensitive inputs into clean, qualified fault flags. The overcurrent comparator bit is hidden for a programmable number of clock cycles after each power-switch turn-on, so the turn-on current spike cannot trip it. A separate hard-short comparator skips both blanking and filtering, so a severe short is seen on the next clock.

The output-voltage and temperature checks work on sampled codes. Trip and clear levels for the voltage checks are derived from a reference code and programmable fixed-point fractions. Each level pair forms a hysteresis band. The temperature check uses a trip code and a hysteresis span. All three conditions pass through a window filter. A flag changes state only after its trip condition, or later its clear condition, has held for a whole programmable window of consecutive samples.

Top module: `prot_qualifier`

## Requirements
- R1: While reset is asserted, and until the first clock edge after the synchronised release, every output flag is 0.
- R2: A turn-on edge is a cycle in which `sw_on` is sampled 1 after being sampled 0 on the previous cycle. `ocp_raw` is ignored in that cycle and in the following `blank_cycles`-1 cycles. A value of 0 disables blanking. A new edge restarts the window.
- R3: Outside the blanking window, `ocp_flag` equals the `ocp_raw` value of the previous cycle.
- R4: `short_flag` equals `short_raw` of the previous cycle in every cycle, whatever the blanking window and the filter states are.
- R5: Fractions are 10-bit values in units of 1/1024. With d(p) = floor(vref*p/1024), the levels are:
  - overvoltage trip = vref + d(ov_trip_pct)
  - overvoltage clear = vref + d(ov_clr_pct)
  - undervoltage trip = vref - d(uv_trip_pct)
  - undervoltage clear = vref - d(uv_clr_pct)
- R6: A flag that is 0 becomes 1 after its trip condition has held on max(`dgl_cycles`,1) consecutive samples. Any sample without the condition restarts the count from zero.
- R7: A flag that is 1 returns to 0 only after its clear condition has held on max(`dgl_cycles`,1) consecutive samples. It uses the same restart rule.
- R8: While a code lies between its trip and clear levels, the flag keeps its value.
- R9: The temperature trip condition is `temp_code` >= `ot_trip_code`. The clear condition is `temp_code` + `ot_hyst_code` < `ot_trip_code`, computed without overflow.
- R10: The overvoltage trip condition is vout >= its trip level, and its clear condition is vout < its clear level. The undervoltage trip condition is vout <= its trip level, and its clear condition is vout > its clear level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_on | input | 1 | Power switch drive level; a rising edge starts blanking |
| ocp_raw | input | 1 | Raw overcurrent comparator |
| short_raw | input | 1 | Raw hard-short comparator |
| vout_code | input | VW | Sampled output-voltage code |
| vref_code | input | VW | Nominal output-voltage code |
| temp_code | input | TW | Sampled temperature code |
| blank_cycles | input | BW | Blanking length in cycles |
| dgl_cycles | input | DW | Filter window in samples |
| ov_trip_pct | input | PW | Overvoltage trip fraction |
| ov_clr_pct | input | PW | Overvoltage clear fraction |
| uv_trip_pct | input | PW | Undervoltage trip fraction |
| uv_clr_pct | input | PW | Undervoltage clear fraction |
| ot_trip_code | input | TW | Temperature trip code |
| ot_hyst_code | input | TW | Temperature hysteresis span |
| ocp_flag | output | 1 | Qualified overcurrent |
| short_flag | output | 1 | Hard-short indication |
| ovp_flag | output | 1 | Qualified overvoltage |
| uvp_flag | output | 1 | Qualified undervoltage |
| otp_flag | output | 1 | Qualified overtemperature |

## Verification
Two cases put functions in the same cycle. In the first, a turn-on edge arrives with both `ocp_raw` and `short_raw` high. The overcurrent bit must be masked while the short is still reported on the next cycle. In the second, a fresh turn-on edge is driven inside, and on the last cycle of, a running blanking window, so that the restart rule and the window end meet. A cycle-by-cycle model in the bench judges every output. It uses the cycles elapsed since the last edge and the consecutive-sample run lengths per channel.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int unsigned PCT_FRAC = 10;
  localparam int unsigned NUM_CH   = 3;

  typedef enum logic [1:0] {
    CH_OV = 2'd0,
    CH_UV = 2'd1,
    CH_OT = 2'd2
  } qual_ch_e;

  // suggested starting fractions (units of 1/1024)
  localparam logic [PCT_FRAC-1:0] DEF_OV_TRIP = 10'd41;
  localparam logic [PCT_FRAC-1:0] DEF_OV_CLR  = 10'd10;
  localparam logic [PCT_FRAC-1:0] DEF_UV_TRIP = 10'd82;
  localparam logic [PCT_FRAC-1:0] DEF_UV_CLR  = 10'd31;
endpackage

// File: rtl/pq_reset_sync.sv
module pq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pq_blank_gate.sv
module pq_blank_gate #(
  parameter int unsigned BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_on,
  input  logic          ocp_raw,
  input  logic          short_raw,
  input  logic [BW-1:0] blank_cycles,
  output logic          ocp_flag,
  output logic          short_flag
);
  logic          sw_q;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          edge_w, blank_zero, blank_act, ocp_d;

  always_comb begin
    edge_w     = sw_on & ~sw_q;
    blank_zero = (blank_cycles == '0);
    cnt_en     = edge_w | (cnt_q != '0);
    if (edge_w) cnt_d = blank_zero ? '0 : blank_cycles - 1'b1;
    else        cnt_d = cnt_q - 1'b1;
    blank_act  = (edge_w & ~blank_zero) | (cnt_q != '0);
    ocp_d      = ocp_raw & ~blank_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q       <= 1'b0;
      cnt_q      <= '0;
      ocp_flag   <= 1'b0;
      short_flag <= 1'b0;
    end else begin
      sw_q       <= sw_on;
      if (cnt_en) cnt_q <= cnt_d;
      ocp_flag   <= ocp_d;
      short_flag <= short_raw;
    end
  end

  // R2: an edge with blanking enabled never reports overcurrent next cycle
  a_r2_edge_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && !blank_zero) |=> !ocp_flag);

  // R3: with no window running and no edge, the comparator passes through
  a_r3_open_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !edge_w) |=> (ocp_flag == $past(ocp_raw)));

  // R4: hard-short path is a plain one-cycle follower
  a_r4_short_follow: assert property (@(posedge clk) disable iff (!rst_n)
    short_raw |=> short_flag);
  a_r4_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !short_raw |=> !short_flag);
endmodule

// File: rtl/pq_thresholds.sv
module pq_thresholds
  import pq_pkg::*;
#(
  parameter int unsigned VW = 10,
  parameter int unsigned TW = 8,
  parameter int unsigned PW = PCT_FRAC
) (
  input  logic [VW-1:0]     vout_code,
  input  logic [VW-1:0]     vref_code,
  input  logic [TW-1:0]     temp_code,
  input  logic [PW-1:0]     ov_trip_pct,
  input  logic [PW-1:0]     ov_clr_pct,
  input  logic [PW-1:0]     uv_trip_pct,
  input  logic [PW-1:0]     uv_clr_pct,
  input  logic [TW-1:0]     ot_trip_code,
  input  logic [TW-1:0]     ot_hyst_code,
  output logic [NUM_CH-1:0] set_cond,
  output logic [NUM_CH-1:0] clr_cond
);
  localparam int unsigned XW = VW + 1;
  localparam int unsigned PRW = VW + PW;

  function automatic logic [VW-1:0] frac_of(input logic [VW-1:0] r,
                                            input logic [PW-1:0] p);
    logic [PRW-1:0] prod;
    prod = PRW'(r) * PRW'(p);
    return prod[PRW-1:PW];
  endfunction

  logic [XW-1:0] vout_x, vref_x;
  logic [XW-1:0] ov_trip, ov_clr, uv_trip, uv_clr;
  logic [TW:0]   temp_sum, trip_x;

  always_comb begin
    vout_x   = {1'b0, vout_code};
    vref_x   = {1'b0, vref_code};
    ov_trip  = vref_x + {1'b0, frac_of(vref_code, ov_trip_pct)};
    ov_clr   = vref_x + {1'b0, frac_of(vref_code, ov_clr_pct)};
    uv_trip  = vref_x - {1'b0, frac_of(vref_code, uv_trip_pct)};
    uv_clr   = vref_x - {1'b0, frac_of(vref_code, uv_clr_pct)};
    temp_sum = {1'b0, temp_code} + {1'b0, ot_hyst_code};
    trip_x   = {1'b0, ot_trip_code};

    set_cond[int'(CH_OV)] = (vout_x >= ov_trip);
    clr_cond[int'(CH_OV)] = (vout_x <  ov_clr);
    set_cond[int'(CH_UV)] = (vout_x <= uv_trip);
    clr_cond[int'(CH_UV)] = (vout_x >  uv_clr);
    set_cond[int'(CH_OT)] = (temp_code >= ot_trip_code);
    clr_cond[int'(CH_OT)] = (temp_sum < trip_x);
  end

  // R9: a temperature can never satisfy trip and clear at once
  always_comb begin
    a_r9_ot_exclusive: assert (!(set_cond[int'(CH_OT)] && clr_cond[int'(CH_OT)]));
  end
endmodule

// File: rtl/pq_window_filter.sv
module pq_window_filter #(
  parameter int unsigned DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_cond,
  input  logic          clr_cond,
  input  logic [DW-1:0] win,
  output logic          flag
);
  logic [DW-1:0] cnt_q, cnt_d, win_m1;
  logic          cnt_en, target, expire, flag_d;

  always_comb begin
    win_m1 = (win == '0) ? '0 : win - 1'b1;
    target = flag ? clr_cond : set_cond;
    expire = target && (cnt_q >= win_m1);
    cnt_en = target || (cnt_q != '0);
    cnt_d  = (!target || expire) ? '0 : cnt_q + 1'b1;
    flag_d = flag ^ expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flag <= flag_d;
    end
  end

  // R6: a rise is always preceded by a sample of the trip condition
  a_r6_rise_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_cond));

  // R6: a broken run restarts the count
  a_r6_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !target |=> (cnt_q == '0));

  // R7: a fall is always preceded by a sample of the clear condition
  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_cond));

  // R8: inside the band the flag holds
  a_r8_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_cond) |=> flag);
  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_cond) |=> !flag);
endmodule

// File: rtl/prot_qualifier.sv
module prot_qualifier
  import pq_pkg::*;
#(
  parameter int unsigned VW = 10,
  parameter int unsigned TW = 8,
  parameter int unsigned BW = 6,
  parameter int unsigned DW = 6,
  parameter int unsigned PW = PCT_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_on,
  input  logic          ocp_raw,
  input  logic          short_raw,
  input  logic [VW-1:0] vout_code,
  input  logic [VW-1:0] vref_code,
  input  logic [TW-1:0] temp_code,
  input  logic [BW-1:0] blank_cycles,
  input  logic [DW-1:0] dgl_cycles,
  input  logic [PW-1:0] ov_trip_pct,
  input  logic [PW-1:0] ov_clr_pct,
  input  logic [PW-1:0] uv_trip_pct,
  input  logic [PW-1:0] uv_clr_pct,
  input  logic [TW-1:0] ot_trip_code,
  input  logic [TW-1:0] ot_hyst_code,
  output logic          ocp_flag,
  output logic          short_flag,
  output logic          ovp_flag,
  output logic          uvp_flag,
  output logic          otp_flag
);
  logic              rst_s_n;
  logic [NUM_CH-1:0] set_c, clr_c, flg;

  pq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pq_blank_gate #(.BW(BW)) u_blank (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .sw_on        (sw_on),
    .ocp_raw      (ocp_raw),
    .short_raw    (short_raw),
    .blank_cycles (blank_cycles),
    .ocp_flag     (ocp_flag),
    .short_flag   (short_flag)
  );

  pq_thresholds #(.VW(VW), .TW(TW), .PW(PW)) u_thr (
    .vout_code    (vout_code),
    .vref_code    (vref_code),
    .temp_code    (temp_code),
    .ov_trip_pct  (ov_trip_pct),
    .ov_clr_pct   (ov_clr_pct),
    .uv_trip_pct  (uv_trip_pct),
    .uv_clr_pct   (uv_clr_pct),
    .ot_trip_code (ot_trip_code),
    .ot_hyst_code (ot_hyst_code),
    .set_cond     (set_c),
    .clr_cond     (clr_c)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pq_window_filter #(.DW(DW)) u_filt (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .set_cond (set_c[g]),
      .clr_cond (clr_c[g]),
      .win      (dgl_cycles),
      .flag     (flg[g])
    );
  end

  assign ovp_flag = flg[int'(CH_OV)];
  assign uvp_flag = flg[int'(CH_UV)];
  assign otp_flag = flg[int'(CH_OT)];

  // R1: nothing is flagged while the synchronised reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_s_n |=> (!ovp_flag && !uvp_flag && !otp_flag && !ocp_flag && !short_flag) || !rst_s_n);
endmodule

// File: tb/tb_prot_qualifier.sv
module tb_prot_qualifier;
  localparam int VW = 10, TW = 8, BW = 6, DW = 6, PW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_on, ocp_raw, short_raw;
  logic [VW-1:0] vout_code, vref_code;
  logic [TW-1:0] temp_code, ot_trip_code, ot_hyst_code;
  logic [BW-1:0] blank_cycles;
  logic [DW-1:0] dgl_cycles;
  logic [PW-1:0] ov_trip_pct, ov_clr_pct, uv_trip_pct, uv_clr_pct;
  logic ocp_flag, short_flag, ovp_flag, uvp_flag, otp_flag;

  always #2 clk = ~clk;

  prot_qualifier #(.VW(VW), .TW(TW), .BW(BW), .DW(DW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .ocp_raw(ocp_raw), .short_raw(short_raw),
    .vout_code(vout_code), .vref_code(vref_code), .temp_code(temp_code),
    .blank_cycles(blank_cycles), .dgl_cycles(dgl_cycles),
    .ov_trip_pct(ov_trip_pct), .ov_clr_pct(ov_clr_pct),
    .uv_trip_pct(uv_trip_pct), .uv_clr_pct(uv_clr_pct),
    .ot_trip_code(ot_trip_code), .ot_hyst_code(ot_hyst_code),
    .ocp_flag(ocp_flag), .short_flag(short_flag), .ovp_flag(ovp_flag),
    .uvp_flag(uvp_flag), .otp_flag(otp_flag)
  );

  int total = 0, bad = 0;
  // reference model state
  int since = 1000;
  bit sw_prev = 0, m_ocp = 0, m_short = 0;
  bit mf [3] = '{0, 0, 0};
  int run [3] = '{0, 0, 0};

  task automatic chk(input logic act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frac(input int r, input int p);
    return (r * p) / 1024;
  endfunction

  task automatic tick();
    int vr, vo, tw, w;
    bit sc [3];
    bit cc [3];
    @(posedge clk);
    vr = int'(vref_code); vo = int'(vout_code);
    if (sw_on && !sw_prev) since = 0;
    else if (since < 1000) since++;
    m_ocp   = ocp_raw && !(since < int'(blank_cycles));
    sw_prev = sw_on;
    m_short = short_raw;
    sc[0] = vo >= vr + frac(vr, int'(ov_trip_pct));
    cc[0] = vo <  vr + frac(vr, int'(ov_clr_pct));
    sc[1] = vo <= vr - frac(vr, int'(uv_trip_pct));
    cc[1] = vo >  vr - frac(vr, int'(uv_clr_pct));
    tw    = int'(temp_code);
    sc[2] = tw >= int'(ot_trip_code);
    cc[2] = tw + int'(ot_hyst_code) < int'(ot_trip_code);
    w = (dgl_cycles == 0) ? 1 : int'(dgl_cycles);
    for (int c = 0; c < 3; c++) begin
      if (mf[c] ? cc[c] : sc[c]) run[c]++;
      else run[c] = 0;
      if (run[c] >= w) begin mf[c] = !mf[c]; run[c] = 0; end
    end
    @(negedge clk);
    chk(ocp_flag,   m_ocp,   "R2/R3 ocp_flag");
    chk(short_flag, m_short, "R4 short_flag");
    chk(ovp_flag,   mf[0],   "R5/R6/R7/R8/R10 ovp_flag");
    chk(uvp_flag,   mf[1],   "R5/R6/R7/R8/R10 uvp_flag");
    chk(otp_flag,   mf[2],   "R6/R7/R8/R9 otp_flag");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : stim
    rst_n = 0; sw_on = 0; ocp_raw = 0; short_raw = 0;
    vref_code = 10'd512; vout_code = 10'd512; temp_code = 0;
    blank_cycles = 6'd3; dgl_cycles = 6'd1;
    ov_trip_pct = 10'd41; ov_clr_pct = 10'd10; uv_trip_pct = 10'd82; uv_clr_pct = 10'd31;
    ot_trip_code = 8'd100; ot_hyst_code = 8'd10;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ocp_flag, 0, "R1 ocp"); chk(short_flag, 0, "R1 short");
    chk(ovp_flag, 0, "R1 ovp"); chk(uvp_flag, 0, "R1 uvp"); chk(otp_flag, 0, "R1 otp");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R3: blanking lengths, restart inside window and on its last cycle
    foreach (blank_cycles_list[k]) begin
      blank_cycles = blank_cycles_list[k];
      ocp_raw = 1; sw_on = 0; ticks(3);
      sw_on = 1; ticks(8);
      sw_on = 0; tick();
      sw_on = 1; tick(); sw_on = 0; tick();
      sw_on = 1; tick(); sw_on = 0;
      if (blank_cycles > 1) ticks(int'(blank_cycles) - 2);
      sw_on = 1; tick(); sw_on = 0; ticks(7);
      for (int i = 0; i < 10; i++) begin
        ocp_raw = i[0]; sw_on = (i == 3); tick();
      end
      ocp_raw = 0; ticks(2);
    end

    // R4 with R2: edge, overcurrent and hard short in the same cycle
    blank_cycles = 6'd4;
    ocp_raw = 1; short_raw = 1; sw_on = 1; tick();
    short_raw = 0; tick();
    short_raw = 1; tick(); short_raw = 0; ticks(4);
    sw_on = 0; ocp_raw = 0; ticks(2);

    // R5 R10 R8: threshold sweeps, filter window of one
    dgl_cycles = 6'd1;
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        ov_trip_pct = 10'd100; ov_clr_pct = 10'd50; uv_trip_pct = 10'd150; uv_clr_pct = 10'd20;
      end
      foreach (vref_list[k]) begin
        vref_code = vref_list[k]; vout_code = vref_code; ticks(2);
        for (int v = 0; v < 1024; v++) begin vout_code = 10'(v); tick(); end
        for (int v = 1023; v >= 0; v--) begin vout_code = 10'(v); tick(); end
        vout_code = vref_code; ticks(2);
      end
    end
    ov_trip_pct = 10'd41; ov_clr_pct = 10'd10; uv_trip_pct = 10'd82; uv_clr_pct = 10'd31;
    vref_code = 10'd512; vout_code = 10'd512; ticks(2);

    // R9: temperature sweep, then a span too large to ever clear
    for (int t = 0; t < 256; t++) begin temp_code = 8'(t); tick(); end
    for (int t = 255; t >= 0; t--) begin temp_code = 8'(t); tick(); end
    temp_code = 8'd120; ticks(2);
    ot_hyst_code = 8'd120;
    for (int t = 120; t >= 0; t--) begin temp_code = 8'(t); tick(); end
    ot_hyst_code = 8'd10; ticks(2);
    temp_code = 0; ticks(3);

    // R6 R7: run lengths around the window, broken clears
    foreach (win_list[k]) begin
      dgl_cycles = win_list[k];
      for (int len = 1; len <= 7; len++) begin
        vout_code = 10'd600; ticks(len);
        vout_code = 10'd512; ticks(len);
        vout_code = 10'd520; tick();
        vout_code = 10'd512; ticks(7);
      end
      for (int len = 1; len <= 6; len++) begin
        vout_code = 10'd400; ticks(len);
        vout_code = 10'd512; ticks(8);
      end
      for (int len = 1; len <= 6; len++) begin
        temp_code = 8'd150; ticks(len);
        temp_code = 8'd95; ticks(2);
        temp_code = 8'd10; ticks(8);
      end
      vout_code = 10'd512; temp_code = 0; ticks(8);
    end

    summary();
    $finish;
  end

  logic [BW-1:0] blank_cycles_list [4] = '{6'd0, 6'd1, 6'd2, 6'd5};
  logic [VW-1:0] vref_list [3] = '{10'd300, 10'd512, 10'd900};
  logic [DW-1:0] win_list [3] = '{6'd0, 6'd3, 6'd5};
endmodule